// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block raises interrupts for a small general-purpose I/O port. On every clock it samples the pin vector. It compares each pin with the value it held on the previous clock. Per-pin configuration then decides which events latch a status bit. An event is an edge of either polarity, a single edge of a chosen polarity, or a level that matches a chosen polarity. Pins driven by the port itself (direction bit 1) are excluded from detection altogether.

Latched events stay in a sticky raw status vector until software clears them through a write-one-to-clear strobe. A mask vector selects which status bits may reach the single combined interrupt line. Register decoding and bus access sit outside the block: configuration arrives as plain vectors and the clear arrives as a strobe with its data.

Top module: `gpio_irq_detect`

## Requirements
- R1: A pin whose direction bit is 1 (output) never sets its status bit, whatever its value does.
- R2: An input pin with level-select 0 and any-edge bit 1 sets its status bit on a rising or a falling change between consecutive clock samples. The bit is visible in `rawStatus` right after the clock edge that samples the new pin value.
- R3: An input pin with level-select 0, any-edge 0 and polarity bit 1 sets its status bit on a rising change only.
- R4: An input pin with level-select 0, any-edge 0 and polarity bit 0 sets its status bit on a falling change only.
- R5: An input pin with level-select 1 sets its status bit on every clock where its value equals its polarity bit, whether or not the pin changed.
- R6: A set status bit stays set, with no further events, until it is cleared.
- R7: On a clock where `clrStrobe` is 1, each status bit whose `clrData` bit is 1 is cleared. Bits whose `clrData` bit is 0 are untouched. A set condition on the same clock wins, so a still-active level source keeps its bit at 1.
- R8: `maskedStatus` equals `rawStatus` AND `irqMask`. `irqOut` is 1 exactly when `maskedStatus` is nonzero.
- R9: After reset all status bits are 0, and the stored previous pin value equals the parameter `PIN_RESET`. Pins sitting at that value therefore produce no edge.
- R10: The previous-value register follows every pin, outputs included. A pin that was an output and is turned into an input at an unchanged value shows no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 8 | Sampled pin values |
| pinDir | input | 8 | Direction per pin, 1 = output |
| senseLevel | input | 8 | 1 = level sensing, 0 = edge sensing |
| bothEdges | input | 8 | 1 = any edge sets status (edge mode) |
| eventPol | input | 8 | 1 = high/rising, 0 = low/falling |
| irqMask | input | 8 | 1 = status bit may drive the interrupt |
| clrStrobe | input | 1 | Clear request valid this clock |
| clrData | input | 8 | Bits to clear, 1 = clear |
| rawStatus | output | 8 | Sticky detected events |
| maskedStatus | output | 8 | Status gated by mask |
| irqOut | output | 1 | OR of masked status |

## Verification
Each pin mode is driven with both a rising and a falling transition. This separates the any-edge mode from the two single-edge polarities: a wrong polarity shows up as a missing or extra status bit. The level mode is held active across a clear and then released across a second clear. This tells a level source that re-sets every clock apart from a latched edge. Output pins are toggled with every mode enabled, and a direction change at a steady value is applied. Together these confirm that output activity never creates status. Mask patterns with single and multiple bits show that the interrupt line tracks only the unmasked bits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PINS = 8;

  typedef struct packed {
    logic [PINS-1:0] setBits;
    logic [PINS-1:0] clrBits;
  } irqStrobes_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter logic [PINS-1:0] PIN_RESET = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] pinIn,
  input  logic [PINS-1:0] pinDir,
  input  logic [PINS-1:0] senseLevel,
  input  logic [PINS-1:0] bothEdges,
  input  logic [PINS-1:0] eventPol,
  input  logic            clrStrobe,
  input  logic [PINS-1:0] clrData,
  output irqStrobes_t     strobes
);
  logic [PINS-1:0] prevIn;
  logic [PINS-1:0] hit;

  // previous sample follows every pin, so a direction change causes no edge
  always_ff @(posedge clk) begin
    if (!rstN) prevIn <= PIN_RESET;
    else       prevIn <= pinIn;
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic polMatch;
    logic changed;
    logic edgeHit;
    assign polMatch = ~(pinIn[i] ^ eventPol[i]);
    assign changed  = pinIn[i] ^ prevIn[i];
    assign edgeHit  = changed & (bothEdges[i] | polMatch);
    assign hit[i]   = ~pinDir[i] & (senseLevel[i] ? polMatch : edgeHit);
  end

  always_comb begin
    strobes.setBits = hit;
    strobes.clrBits = clrStrobe ? clrData : '0;
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
  import gpio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  irqStrobes_t     strobes,
  input  logic [PINS-1:0] irqMask,
  output logic [PINS-1:0] rawStatus,
  output logic [PINS-1:0] maskedStatus,
  output logic            irqOut
);
  logic [PINS-1:0] statusQ;

  // set wins over a clear in the same clock
  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~strobes.clrBits) | strobes.setBits;
  end

  assign rawStatus    = statusQ;
  assign maskedStatus = statusQ & irqMask;
  assign irqOut       = |maskedStatus;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter logic [7:0] PIN_RESET = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] pinIn,
  input  logic [7:0] pinDir,
  input  logic [7:0] senseLevel,
  input  logic [7:0] bothEdges,
  input  logic [7:0] eventPol,
  input  logic [7:0] irqMask,
  input  logic       clrStrobe,
  input  logic [7:0] clrData,
  output logic [7:0] rawStatus,
  output logic [7:0] maskedStatus,
  output logic       irqOut
);
  irqStrobes_t strobes;

  gpio_irq_ctrl #(.PIN_RESET(PIN_RESET)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinDir(pinDir),
    .senseLevel(senseLevel), .bothEdges(bothEdges), .eventPol(eventPol),
    .clrStrobe(clrStrobe), .clrData(clrData), .strobes(strobes)
  );

  gpio_irq_status u_status (
    .clk(clk), .rstN(rstN), .strobes(strobes), .irqMask(irqMask),
    .rawStatus(rawStatus), .maskedStatus(maskedStatus), .irqOut(irqOut)
  );
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] pinIn,
  input logic [7:0] pinDir,
  input logic [7:0] senseLevel,
  input logic [7:0] eventPol,
  input logic [7:0] irqMask,
  input logic       clrStrobe,
  input logic [7:0] clrData,
  input logic [7:0] rawStatus,
  input logic [7:0] maskedStatus,
  input logic       irqOut
);
  p_irq_has_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (rawStatus != 8'h00));
  p_masked_subset_r8: assert property (@(posedge clk) disable iff (!rstN)
    (maskedStatus & ~rawStatus) == 8'h00);

  for (genvar i = 0; i < 8; i++) begin : g_bit
    p_output_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
      (pinDir[i] && clrStrobe && clrData[i]) |=> !rawStatus[i]);
    p_level_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!pinDir[i] && senseLevel[i] && (pinIn[i] == eventPol[i])) |=> rawStatus[i]);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
      (rawStatus[i] && !(clrStrobe && clrData[i])) |=> rawStatus[i]);
  end
endmodule

bind gpio_irq_detect gpio_irq_checker u_chk (
  .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinDir(pinDir),
  .senseLevel(senseLevel), .eventPol(eventPol), .irqMask(irqMask),
  .clrStrobe(clrStrobe), .clrData(clrData), .rawStatus(rawStatus),
  .maskedStatus(maskedStatus), .irqOut(irqOut)
);

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] pinIn, pinDir, senseLevel, bothEdges, eventPol, irqMask, clrData;
  logic       clrStrobe;
  logic [7:0] rawStatus, maskedStatus;
  logic       irqOut;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  gpio_irq_detect dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinDir(pinDir),
    .senseLevel(senseLevel), .bothEdges(bothEdges), .eventPol(eventPol),
    .irqMask(irqMask), .clrStrobe(clrStrobe), .clrData(clrData),
    .rawStatus(rawStatus), .maskedStatus(maskedStatus), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; pinIn = 8'h00; pinDir = 8'h00; senseLevel = 8'h00;
    bothEdges = 8'h00; eventPol = 8'h00; irqMask = 8'h00;
    clrStrobe = 1'b0; clrData = 8'h00;
    step(); step();
    rstN = 1'b1;
  endtask

  task automatic clearBits(input logic [7:0] bits);
    clrStrobe = 1'b1; clrData = bits;
    step();
    clrStrobe = 1'b0; clrData = 8'h00;
  endtask

  task automatic testReset();
    doReset();
    step(); step();
    check("R9 status after reset", rawStatus, 8'h00);
    check("R9 irq after reset", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic testOutputPins();
    doReset();
    pinDir = 8'hFF; bothEdges = 8'hFF; senseLevel = 8'h0F; eventPol = 8'hFF;
    irqMask = 8'hFF;
    pinIn = 8'hFF; step();
    pinIn = 8'h00; step();
    check("R1 output pins set nothing", rawStatus, 8'h00);
  endtask

  task automatic testAnyEdge();
    doReset();
    bothEdges = 8'h01;
    pinIn = 8'h01; step();
    check("R2 rising any-edge", rawStatus, 8'h01);
    clearBits(8'h01);
    check("R7 clear after edge", rawStatus, 8'h00);
    pinIn = 8'h00; step();
    check("R2 falling any-edge", rawStatus, 8'h01);
  endtask

  task automatic testRising();
    doReset();
    eventPol = 8'h02;
    pinIn = 8'h02; step();
    check("R3 rising sets", rawStatus, 8'h02);
    clearBits(8'h02);
    pinIn = 8'h00; step();
    check("R3 falling ignored", rawStatus, 8'h00);
    step(); step(); step();
    pinIn = 8'h02; step();
    step(); step(); step();
    check("R6 stays set", rawStatus, 8'h02);
  endtask

  task automatic testFalling();
    doReset();
    eventPol = 8'h00;
    pinIn = 8'h04; step();
    check("R4 rising ignored", rawStatus, 8'h00);
    pinIn = 8'h00; step();
    check("R4 falling sets", rawStatus, 8'h04);
  endtask

  task automatic testLevel();
    doReset();
    senseLevel = 8'h08; eventPol = 8'h08;
    pinIn = 8'h08; step();
    check("R5 level high sets", rawStatus, 8'h08);
    clearBits(8'h08);
    check("R7 level wins over clear", rawStatus, 8'h08);
    pinIn = 8'h00; step();
    clearBits(8'h08);
    step();
    check("R5 inactive level stays clear", rawStatus, 8'h00);
    eventPol = 8'h00; step();
    check("R5 level low sets without change", rawStatus, 8'h08);
  endtask

  task automatic testClearAndMask();
    doReset();
    bothEdges = 8'h30;
    pinIn = 8'h30; step();
    check("R2 two pins", rawStatus, 8'h30);
    clearBits(8'h00);
    check("R7 clear zero no effect", rawStatus, 8'h30);
    irqMask = 8'h00; #1;
    check("R8 all masked", {maskedStatus[7:1], irqOut}, 8'h00);
    irqMask = 8'h10; #1;
    check("R8 masked value", maskedStatus, 8'h10);
    check("R8 irq high", {7'd0, irqOut}, 8'h01);
    clearBits(8'h10);
    check("R7 single bit cleared", rawStatus, 8'h20);
    check("R8 irq low after clear", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic testDirSwitch();
    doReset();
    pinDir = 8'h40; bothEdges = 8'h40;
    pinIn = 8'h40; step(); step();
    pinDir = 8'h00; step(); step();
    check("R10 no edge on direction change", rawStatus, 8'h00);
  endtask

  initial begin
    rstN = 1'b0; pinIn = 8'h00; pinDir = 8'h00; senseLevel = 8'h00;
    bothEdges = 8'h00; eventPol = 8'h00; irqMask = 8'h00;
    clrStrobe = 1'b0; clrData = 8'h00;
    testReset();
    testOutputPins();
    testAnyEdge();
    testRising();
    testFalling();
    testLevel();
    testClearAndMask();
    testDirSwitch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule